// File: doc/BRIEF.md
# Serial Byte Transmitter with Selectable Interrupt Points

This block serialises bytes onto one line as asynchronous frames. A four-entry character store accepts parallel writes and feeds a frame shifter. The shifter paces every bit from an external baud tick that is one clock long. The block does not generate the bit rate itself. It raises a single-cycle interrupt pulse at one of three points in the transmit flow, chosen by a 2-bit mode input.

Two status flags report the state of the path. One says the store is full. The other says both the store and the shifter are empty.

A pulse on the break input makes the next frame a long run of zeros. The request is held internally and drops by itself once that frame has finished. The resting level of the line can be inverted, and the meaning of the invert control depends on an infrared-mode flag. Dropping the enable stops the current frame, discards everything stored and hands the pin back to general-purpose logic.

Top module: `uart_tx_irq`

## Requirements
- R1: A character frame is a 0 start bit, then the eight data bits least significant first, then a 1 stop bit. Each bit spans exactly one baud-tick interval. Frames begin only on a baud tick, and frames for stored characters follow one another with no idle gap.
- R2: The store holds up to 4 characters and `buf_full` is 1 while it holds 4. A write while the store is full is dropped. A write while `tx_en` is 0 is also dropped.
- R3: `sr_empty` is 1 exactly when the shifter is idle and the store is empty. It is 1 after reset and 0 while any character is stored or being sent.
- R4: With `irq_mode` 2'b00, `irq` is high for one cycle, in the clock cycle after each character moves from the store into the shifter. Mode 2'b11 behaves exactly like 2'b00.
- R5: With `irq_mode` 2'b10, `irq` pulses only when a move into the shifter leaves the store empty.
- R6: With `irq_mode` 2'b01, `irq` pulses only when a frame's stop bit ends and nothing remains to send.
- R7: A one-cycle pulse on `brk_req` makes the next frame a break. A break is a 0 start bit, then twelve 0 bits, then a 1 stop bit, and it consumes no stored character. The request clears itself when that frame ends, and stored characters follow as normal frames.
- R8: The line carries the frame level XOR an invert term. The invert term is 1 when (`irda_mode`=0, `idle_inv`=1) or (`irda_mode`=1, `idle_inv`=0). The idle line is therefore low in those two cases and high otherwise.
- R9: While `tx_en` is 0, `tx_oe` is 0. Any frame in progress is abandoned, the store is emptied and a pending break is discarded. `tx_line` rests at the idle level, and after re-enabling nothing is sent until new writes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 aborts and flushes |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to store |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| irq_mode | input | 2 | Interrupt point: 00 load, 01 drained, 10 last load, 11 as 00 |
| brk_req | input | 1 | Pulse to request a break frame |
| idle_inv | input | 1 | Idle-level invert control |
| irda_mode | input | 1 | Swaps the meaning of idle_inv |
| tx_line | output | 1 | Serial output |
| tx_oe | output | 1 | 1 while the block drives the pin |
| irq | output | 1 | One-cycle interrupt pulse |
| buf_full | output | 1 | Store holds 4 characters |
| sr_empty | output | 1 | Store and shifter both empty |

## Verification
Single bytes, bursts of four sent back-to-back, and a fifth write into a full store are each decoded from the line. These cases separate correct framing and bit order from dropped, duplicated or gapped frames. The same three-character burst is replayed under every interrupt mode, with the tick index of each pulse compared against frame starts and stop-bit ends. A break ahead of a stored byte shows that the zero run is exactly thirteen bits long, that the byte survives and that the break does not repeat. All four polarity combinations, an abort in mid-frame and writes made while disabled check line level, flushing and the pin release.

// File: rtl/uart_tx_pkg.sv
// Package: shared interrupt-mode codes for the serial transmitter.
// Assumes: mode values are fixed by the interface and must not be renumbered.
package uart_tx_pkg;
    localparam logic [1:0] IRQ_ON_LOAD      = 2'b00;
    localparam logic [1:0] IRQ_ON_DRAIN     = 2'b01;
    localparam logic [1:0] IRQ_ON_LAST_LOAD = 2'b10;
    localparam logic [1:0] IRQ_RESERVED     = 2'b11;
endpackage

// File: rtl/uart_tx_buf.sv
// Module: character store, a circular first-in first-out queue.
// Assumes: push is pre-qualified by the caller; a push when full or a pop when
// empty is ignored here as well; flush has priority over everything.
module uart_tx_buf #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  cnt,
    output logic              full,
    output logic              empty
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    // Qualify the requests against the occupancy.
    always_comb begin
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    // Store the incoming character in the slot addressed by the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt <= cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Present the oldest character and the occupancy flags.
    always_comb begin
        dout  = mem[rd_ptr];
        full  = (cnt == FULL_CNT);
        empty = (cnt == '0);
    end
endmodule

// File: rtl/uart_tx_frame.sv
// Module: frame shifter. It builds a character frame or a break frame and
// shifts it out, one bit per baud tick, least significant bit first.
// Assumes: baud_tick is one clock wide. A new frame loads only on a tick, when
// the shifter is idle or is finishing its last bit. A break outranks a stored
// character.
module uart_tx_frame #(
    parameter int DATA_W    = 8,
    parameter int BRK_ZEROS = 12,
    localparam int CHR_BITS = DATA_W + 2,
    localparam int BRK_BITS = BRK_ZEROS + 2,
    localparam int SR_W     = (CHR_BITS > BRK_BITS) ? CHR_BITS : BRK_BITS,
    localparam int LEFT_W   = $clog2(SR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    input  logic              brk_pending,
    output logic              line_bit,
    output logic              busy,
    output logic              load_chr,
    output logic              load_any,
    output logic              frame_done,
    output logic              brk_done
);
    logic [SR_W-1:0]   sr;
    logic [LEFT_W-1:0] left;
    logic              is_brk;
    logic              last_bit;
    logic              slot;
    logic              load_brk;
    logic [SR_W-1:0]   chr_word;
    logic [SR_W-1:0]   brk_word;

    // Build the two frame images: a character frame and a break frame.
    always_comb begin
        for (int i = 0; i < SR_W; i++) begin
            if (i == 0) begin
                chr_word[i] = 1'b0;
            end else if (i <= DATA_W) begin
                chr_word[i] = data[i-1];
            end else begin
                chr_word[i] = 1'b1;
            end
            brk_word[i] = (i > BRK_ZEROS);
        end
    end

    // Decide when a frame ends and which frame, if any, loads on this tick.
    always_comb begin
        last_bit   = busy && (left == LEFT_W'(1));
        slot       = baud_tick && tx_en && (!busy || last_bit);
        load_brk   = slot && brk_pending && !(last_bit && is_brk);
        load_chr   = slot && !load_brk && have_data;
        load_any   = load_brk || load_chr;
        frame_done = baud_tick && tx_en && last_bit;
        brk_done   = frame_done && is_brk;
        line_bit   = sr[0];
    end

    // Load, shift and retire frames; an abort returns to the idle image.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            sr     <= '1;
            left   <= '0;
            busy   <= 1'b0;
            is_brk <= 1'b0;
        end else if (load_brk) begin
            sr     <= brk_word;
            left   <= LEFT_W'(BRK_BITS);
            busy   <= 1'b1;
            is_brk <= 1'b1;
        end else if (load_chr) begin
            sr     <= chr_word;
            left   <= LEFT_W'(CHR_BITS);
            busy   <= 1'b1;
            is_brk <= 1'b0;
        end else if (baud_tick && busy) begin
            if (last_bit) begin
                sr     <= '1;
                left   <= '0;
                busy   <= 1'b0;
                is_brk <= 1'b0;
            end else begin
                sr   <= {1'b1, sr[SR_W-1:1]};
                left <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_irq_gen.sv
// Module: interrupt point selector. It produces a registered, one-cycle pulse.
// Assumes: count is the store occupancy before this cycle's push or pop. The
// reserved mode code is treated as the per-load mode.
module uart_tx_irq_gen #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [1:0]       mode,
    input  logic             load_chr,
    input  logic             push_ok,
    input  logic [CNT_W-1:0] count,
    input  logic             frame_done,
    input  logic             load_any,
    output logic             irq
);
    import uart_tx_pkg::*;

    logic fire;

    // Pick the trigger event for the selected mode.
    always_comb begin
        case (mode)
            IRQ_ON_DRAIN:     fire = frame_done && !load_any;
            IRQ_ON_LAST_LOAD: fire = load_chr && (count == CNT_W'(1)) && !push_ok;
            IRQ_ON_LOAD,
            IRQ_RESERVED:     fire = load_chr;
            default:          fire = load_chr;
        endcase
    end

    // Register the pulse so that it lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= tx_en && fire;
        end
    end
endmodule

// File: rtl/uart_tx_irq.sv
// Module: top of the serial transmitter. It joins the store, the shifter and
// the interrupt selector, and holds the break request and the line polarity.
// Assumes: brk_req is a pulse; a request made while a break is already pending
// merges with it. The line polarity inputs may change at any time.
module uart_tx_irq #(
    parameter int DEPTH     = 4,
    parameter int DATA_W    = 8,
    parameter int BRK_ZEROS = 12,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    input  logic [1:0]        irq_mode,
    input  logic              brk_req,
    input  logic              idle_inv,
    input  logic              irda_mode,
    output logic              tx_line,
    output logic              tx_oe,
    output logic              irq,
    output logic              buf_full,
    output logic              sr_empty
);
    logic              push_ok;
    logic              buf_empty;
    logic [CNT_W-1:0]  buf_cnt;
    logic [DATA_W-1:0] head;
    logic              brk_pend;
    logic              line_bit;
    logic              busy;
    logic              load_chr;
    logic              load_any;
    logic              frame_done;
    logic              brk_done;
    logic              invert;

    // Accept a write only while enabled and not full.
    always_comb begin
        push_ok = wr_valid && tx_en && !buf_full;
    end

    uart_tx_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!tx_en),
        .push  (push_ok),
        .din   (wr_data),
        .pop   (load_chr),
        .dout  (head),
        .cnt   (buf_cnt),
        .full  (buf_full),
        .empty (buf_empty)
    );

    // Hold a break request until its frame completes; disabling discards it.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            brk_pend <= 1'b0;
        end else if (brk_req) begin
            brk_pend <= 1'b1;
        end else if (brk_done) begin
            brk_pend <= 1'b0;
        end
    end

    uart_tx_frame #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .baud_tick   (baud_tick),
        .have_data   (!buf_empty),
        .data        (head),
        .brk_pending (brk_pend),
        .line_bit    (line_bit),
        .busy        (busy),
        .load_chr    (load_chr),
        .load_any    (load_any),
        .frame_done  (frame_done),
        .brk_done    (brk_done)
    );

    uart_tx_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .mode       (irq_mode),
        .load_chr   (load_chr),
        .push_ok    (push_ok),
        .count      (buf_cnt),
        .frame_done (frame_done),
        .load_any   (load_any),
        .irq        (irq)
    );

    // Apply the line polarity and drive the status outputs.
    always_comb begin
        invert   = irda_mode ? !idle_inv : idle_inv;
        tx_line  = line_bit ^ invert;
        tx_oe    = tx_en;
        sr_empty = !busy && buf_empty;
    end
endmodule

// File: rtl/uart_tx_irq_chk.sv
// Module: property checker for the serial transmitter, bound to the top module.
// Assumes: it observes ports and the store occupancy only, and drives nothing.
module uart_tx_irq_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             wr_valid,
    input logic             baud_tick,
    input logic [1:0]       irq_mode,
    input logic             idle_inv,
    input logic             irda_mode,
    input logic             tx_line,
    input logic             irq,
    input logic             buf_full,
    input logic             sr_empty,
    input logic [CNT_W-1:0] buf_cnt
);
    // A full store stays full when no tick can drain it.
    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && tx_en && !baud_tick) |=> buf_full);

    // The idle line sits at the level selected by the polarity inputs.
    p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_empty |-> (tx_line == (irda_mode ? idle_inv : !idle_inv)));

    // The line changes only after a baud tick while enabled with fixed polarity.
    p_edge_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $stable(idle_inv) && $stable(irda_mode)
         && !$stable(tx_line)) |-> $past(baud_tick));

    // Every interrupt follows a baud tick (R4).
    p_irq_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(baud_tick));

    // In the last-load mode the store is empty when the pulse appears.
    p_last_load_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_mode) == 2'b10 && !$past(wr_valid)) |-> (buf_cnt == '0));

    // In the drained mode everything is idle when the pulse appears.
    p_drain_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_mode) == 2'b01 && !$past(wr_valid)) |-> sr_empty);

    // Disabling empties the path on the next cycle.
    p_disable_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (sr_empty && !buf_full && !irq));
endmodule

bind uart_tx_irq uart_tx_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .wr_valid  (wr_valid),
    .baud_tick (baud_tick),
    .irq_mode  (irq_mode),
    .idle_inv  (idle_inv),
    .irda_mode (irda_mode),
    .tx_line   (tx_line),
    .irq       (irq),
    .buf_full  (buf_full),
    .sr_empty  (sr_empty),
    .buf_cnt   (buf_cnt)
);

// File: tb/uart_tx_irq_bench.sv
// Bench: directed scenarios for the serial transmitter; each task checks itself.
module uart_tx_irq_bench;
    localparam int BAUD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic [1:0] irq_mode = 2'b00;
    logic       brk_req = 1'b0;
    logic       idle_inv = 1'b0;
    logic       irda_mode = 1'b0;
    logic       tx_line;
    logic       tx_oe;
    logic       irq;
    logic       buf_full;
    logic       sr_empty;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    logic inv_exp = 1'b0;

    logic cap [512];
    int   cap_n = 0;
    int   irq_n = 0;
    int   irq_at [64];
    int   fr_n;
    int   fr_err;
    int   fr_start [16];
    logic [7:0] fr_data [16];

    uart_tx_irq u_uart_tx_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .baud_tick (baud_tick),
        .irq_mode  (irq_mode),
        .brk_req   (brk_req),
        .idle_inv  (idle_inv),
        .irda_mode (irda_mode),
        .tx_line   (tx_line),
        .tx_oe     (tx_oe),
        .irq       (irq),
        .buf_full  (buf_full),
        .sr_empty  (sr_empty)
    );

    always #4 clk = !clk;

    // Log each interrupt pulse with the current sample index.
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (irq_n < 64) irq_at[irq_n] = cap_n;
            irq_n = irq_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Sample the normalised line, then issue one baud tick and wait one interval.
    task automatic tick();
        @(negedge clk);
        cap[cap_n] = tx_line ^ inv_exp;
        cap_n = cap_n + 1;
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        repeat (BAUD - 2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic clear_log();
        cap_n = 0;
        irq_n = 0;
    endtask

    // Split the captured samples into 8N1 frames.
    task automatic decode(input int from);
        int i;
        fr_n = 0;
        fr_err = 0;
        i = from;
        while (i < cap_n) begin
            if (cap[i] == 1'b0 && i + 9 < cap_n) begin
                if (fr_n < 16) begin
                    fr_start[fr_n] = i;
                    for (int k = 0; k < 8; k++) fr_data[fr_n][k] = cap[i + 1 + k];
                end
                if (cap[i + 9] != 1'b1) fr_err = fr_err + 1;
                fr_n = fr_n + 1;
                i = i + 10;
            end else begin
                if (cap[i] == 1'b0) fr_err = fr_err + 1;
                i = i + 1;
            end
        end
    endtask

    function automatic int count_zeros();
        int z = 0;
        for (int i = 0; i < cap_n; i++) if (cap[i] == 1'b0) z = z + 1;
        return z;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(sr_empty == 1'b1, "R3 reset sr_empty", sr_empty, 1);
        check(buf_full == 1'b0, "R2 reset buf_full", buf_full, 0);
        check(irq == 1'b0, "R4 reset irq", irq, 0);
        check(tx_line == 1'b1, "R8 reset idle high", tx_line, 1);
        check(tx_oe == 1'b0, "R9 disabled tx_oe", tx_oe, 0);
    endtask

    task automatic t_single();
        irq_mode = 2'b00;
        tx_en = 1'b1;
        tick();
        check(tx_oe == 1'b1, "R9 enabled tx_oe", tx_oe, 1);
        clear_log();
        wr(8'hA5);
        check(sr_empty == 1'b0, "R3 sr_empty after write", sr_empty, 0);
        ticks(14);
        decode(0);
        check(fr_n == 1 && fr_err == 0, "R1 single frame count", fr_n, 1);
        check(fr_data[0] == 8'hA5, "R1 single data", fr_data[0], 8'hA5);
        check(irq_n == 1, "R4 single irq count", irq_n, 1);
        check(irq_at[0] == fr_start[0], "R4 irq at load", irq_at[0], fr_start[0]);
        check(sr_empty == 1'b1, "R3 sr_empty after frame", sr_empty, 1);
    endtask

    task automatic t_fill();
        irq_mode = 2'b00;
        clear_log();
        wr(8'h11); wr(8'h22); wr(8'h33);
        check(buf_full == 1'b0, "R2 three held not full", buf_full, 0);
        wr(8'h44);
        check(buf_full == 1'b1, "R2 four held full", buf_full, 1);
        wr(8'h55);
        check(buf_full == 1'b1, "R2 full after extra write", buf_full, 1);
        ticks(48);
        decode(0);
        check(fr_n == 4 && fr_err == 0, "R2 extra write dropped", fr_n, 4);
        for (int k = 0; k < 4; k++) begin
            check(fr_data[k] == 8'(8'h11 * (k + 1)), "R1 burst data", fr_data[k], 8'h11 * (k + 1));
        end
        for (int k = 0; k < 3; k++) begin
            check(fr_start[k + 1] == fr_start[k] + 10, "R1 back-to-back", fr_start[k + 1], fr_start[k] + 10);
        end
        check(irq_n == 4, "R4 irq per load", irq_n, 4);
    endtask

    task automatic t_mode(input logic [1:0] m, input int n_exp, input string req);
        irq_mode = m;
        clear_log();
        wr(8'h01); wr(8'h80); wr(8'hC3);
        ticks(40);
        decode(0);
        check(fr_n == 3 && fr_err == 0, {req, " frames"}, fr_n, 3);
        check(irq_n == n_exp, {req, " irq count"}, irq_n, n_exp);
        if (m == 2'b10) begin
            check(irq_at[0] == fr_start[2], "R5 irq at final load", irq_at[0], fr_start[2]);
        end else if (m == 2'b01) begin
            check(irq_at[0] == fr_start[2] + 10, "R6 irq at last stop end", irq_at[0], fr_start[2] + 10);
        end
    endtask

    task automatic t_break();
        int s;
        int z;
        irq_mode = 2'b01;
        clear_log();
        pulse_brk();
        wr(8'h3C);
        ticks(40);
        s = -1;
        for (int i = 0; i < cap_n; i++) if (s < 0 && cap[i] == 1'b0) s = i;
        z = 0;
        for (int i = 0; i < 13; i++) if (s >= 0 && cap[s + i] == 1'b0) z = z + 1;
        check(s >= 0 && z == 13, "R7 break zero run", z, 13);
        check(s >= 0 && cap[s + 13] == 1'b1, "R7 break stop bit", cap[s + 13], 1);
        decode(s + 14);
        check(fr_n == 1 && fr_err == 0, "R7 break self-clears", fr_n, 1);
        check(fr_data[0] == 8'h3C, "R7 stored byte kept", fr_data[0], 8'h3C);
        check(irq_n == 1, "R6 one drain irq after break", irq_n, 1);
    endtask

    task automatic t_polarity();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            irda_mode = c[1];
            idle_inv  = c[0];
            @(negedge clk);
            check(tx_line == (c[1] ? c[0] : !c[0]), "R8 idle level", tx_line, c[1] ? c[0] : !c[0]);
        end
        @(negedge clk);
        irda_mode = 1'b0;
        idle_inv  = 1'b1;
        inv_exp   = 1'b1;
        clear_log();
        wr(8'h96);
        ticks(14);
        decode(0);
        check(fr_n == 1 && fr_data[0] == 8'h96, "R8 inverted frame", fr_data[0], 8'h96);
        irda_mode = 1'b0;
        idle_inv  = 1'b0;
        inv_exp   = 1'b0;
    endtask

    task automatic t_abort();
        irq_mode = 2'b00;
        wr(8'hF0); wr(8'h0F); wr(8'hAA);
        ticks(4);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        check(tx_oe == 1'b0, "R9 abort tx_oe", tx_oe, 0);
        check(sr_empty == 1'b1, "R9 abort flushed", sr_empty, 1);
        check(tx_line == 1'b1, "R9 abort idle line", tx_line, 1);
        wr(8'h5A);
        pulse_brk();
        @(negedge clk);
        tx_en = 1'b1;
        clear_log();
        ticks(30);
        check(count_zeros() == 0, "R9 nothing sent after re-enable", count_zeros(), 0);
        check(sr_empty == 1'b1, "R2 disabled write dropped", sr_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_fill();
        t_mode(2'b00, 3, "R4 mode00");
        t_mode(2'b11, 3, "R4 mode11");
        t_mode(2'b10, 1, "R5 mode10");
        t_mode(2'b01, 1, "R6 mode01");
        t_break();
        t_polarity();
        t_abort();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule